// File: doc/BRIEF.md
# Audio Master-Mode Clock Generator

This block produces the bit clock and the left/right frame clock of a serial audio port when that port runs as clock master. It divides a master clock that runs at 256, 512 or 768 times the sample rate. The same generator can drive either the receive or the transmit side of a converter, whichever side is synchronous to the master clock. A frame holds 64 bit clocks, 32 per channel, so the bit clock is the master clock divided by 4, 8 or 12. It has a 50% duty cycle at every ratio.

A 3-bit mode code selects slave operation or one of the three ratios. In slave operation both clock outputs are held low. A one-cycle strobe marks the start of every frame. A change of mode takes effect only at the end of a complete bit-clock period, so no shortened pulse ever reaches the outputs. A synchronous active-high reset and a clock enable complete the interface.

Top module: `audio_mclk_clkgen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `bclk_o`, `lrclk_o` and `frame_start_o` are low and the block is in slave operation.
- R2: Mode codes 000 and 100 to 111 select slave operation: all three outputs stay low.
- R3: Mode code 001 (256x) gives a bit clock of 4 master cycles, low for 2 and then high for 2.
- R4: Mode code 010 (512x) gives a bit clock of 8 master cycles, low for 4 and then high for 4.
- R5: Mode code 011 (768x) gives a bit clock of 12 master cycles, low for 6 and then high for 6.
- R6: `lrclk_o` is low for 32 bit-clock periods and then high for 32. It changes only in the cycle in which `bclk_o` falls.
- R7: `frame_start_o` is high for exactly one master cycle, in the cycle where a frame begins. In that cycle `lrclk_o` and `bclk_o` are low.
- R8: When leaving slave operation, the first enabled edge with a master code starts a frame: `frame_start_o` goes high and `bclk_o` begins its low half.
- R9: A mode change made during master operation takes effect at the end of the current bit-clock period. The counters then restart from the frame start, and no bit-clock pulse is shorter than its half period.
- R10: While `en` is low, `bclk_o`, `lrclk_o` and all counters hold their values, `frame_start_o` is low, and mode changes wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; low freezes the generator |
| mode_sel | input | 3 | Mode code: 000 slave, 001 256x, 010 512x, 011 768x, others slave |
| bclk_o | output | 1 | Bit clock, 64 per frame |
| lrclk_o | output | 1 | Frame clock, low for the first channel |
| frame_start_o | output | 1 | One-cycle strobe at each frame start |

## Verification
The assertions assume that `mode_sel` and `en` are synchronous to the master clock and settle between edges. They also assume that reset is held for at least one edge before any output is judged. The bench changes every input a short delay after a falling master-clock edge and applies reset from time zero. A behavioural model runs in step with the design and is compared on every cycle. The stimulus includes mode changes in the middle of a bit-clock period and while the enable is low.

// File: rtl/audio_mclk_pkg.sv
package audio_mclk_pkg;

    // Ratio selected for the master clock versus the sample rate
    typedef enum logic [1:0] {
        RATIO_NONE = 2'd0,
        RATIO_256  = 2'd1,
        RATIO_512  = 2'd2,
        RATIO_768  = 2'd3
    } ratio_e;

    localparam int RATIO_STEPS = 3;

    localparam logic [2:0] MSEL_SLAVE = 3'b000;
    localparam logic [2:0] MSEL_X256  = 3'b001;
    localparam logic [2:0] MSEL_X512  = 3'b010;
    localparam logic [2:0] MSEL_X768  = 3'b011;

    // Output bundle of the generator
    typedef struct packed {
        logic bclk;
        logic lrclk;
        logic fstart;
    } clk_out_t;

    function automatic ratio_e decode_mode(input logic [2:0] code);
        ratio_e r;
        case (code)
            MSEL_X256: r = RATIO_256;
            MSEL_X512: r = RATIO_512;
            MSEL_X768: r = RATIO_768;
            default:   r = RATIO_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mclk_mode_ctrl.sv
module mclk_mode_ctrl
    import audio_mclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] mode_in,
    input  logic       period_end,
    output ratio_e     cur_ratio,
    output ratio_e     next_ratio,
    output logic       load
);

    ratio_e req;
    ratio_e cur_q;

    always_comb begin
        req = decode_mode(mode_in);
        if (!en) begin
            load = 1'b0;
        end else if (cur_q == RATIO_NONE) begin
            load = (req != RATIO_NONE);
        end else begin
            load = period_end && (req != cur_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= RATIO_NONE;
        end else if (load) begin
            cur_q <= req;
        end
    end

    assign cur_ratio  = cur_q;
    assign next_ratio = req;

    AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst) (($past(cur_q) != RATIO_NONE) && (cur_q != $past(cur_q))) |-> $past(period_end)); // R9

endmodule

// File: rtl/mclk_bit_div.sv
module mclk_bit_div
    import audio_mclk_pkg::*;
#(
    parameter int HALF_UNIT = 2,
    parameter int PH_W      = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   load,
    input  ratio_e cur_ratio,
    output logic   bclk,
    output logic   period_end
);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] ph_inc;
    logic [PH_W-1:0] half_c;
    logic [PH_W-1:0] last_c;
    logic            active;

    always_comb begin
        active     = (cur_ratio != RATIO_NONE);
        half_c     = PH_W'(int'(cur_ratio) * HALF_UNIT);
        last_c     = PH_W'(2 * int'(cur_ratio) * HALF_UNIT - 1);
        ph_inc     = ph + 1'b1;
        period_end = active && (ph == last_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= '0;
            bclk <= 1'b0;
        end else if (en) begin
            if (load || !active || period_end) begin
                ph   <= '0;
                bclk <= 1'b0;
            end else begin
                ph   <= ph_inc;
                bclk <= (ph_inc >= half_c);
            end
        end
    end

    AST_BCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst) $fell(bclk) |-> $past(bclk, 2)); // R9
    AST_BCLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(bclk) |-> !$past(bclk, 2)); // R9
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst) active |-> (ph <= last_c)); // R3

endmodule

// File: rtl/mclk_frame_cnt.sv
module mclk_frame_cnt #(
    parameter int FRAME_BITS = 64,
    parameter int BIDX_W     = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic load,
    input  logic load_active,
    input  logic tick,
    output logic lrclk,
    output logic fstart
);

    localparam int HALF_FRAME = FRAME_BITS / 2;

    logic [BIDX_W-1:0] bidx;
    logic [BIDX_W-1:0] bidx_nxt;

    always_comb begin
        if (bidx == BIDX_W'(FRAME_BITS - 1)) begin
            bidx_nxt = '0;
        end else begin
            bidx_nxt = bidx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bidx   <= '0;
            lrclk  <= 1'b0;
            fstart <= 1'b0;
        end else if (!en) begin
            fstart <= 1'b0;
        end else if (load) begin
            bidx   <= '0;
            lrclk  <= 1'b0;
            fstart <= load_active;
        end else if (tick) begin
            bidx   <= bidx_nxt;
            lrclk  <= (bidx_nxt >= BIDX_W'(HALF_FRAME));
            fstart <= (bidx_nxt == '0);
        end else begin
            fstart <= 1'b0;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) fstart |=> !fstart); // R7
    AST_WRAP_STROBE: assert property (@(posedge clk) disable iff (rst) (en && tick && !load && (bidx == BIDX_W'(FRAME_BITS - 1))) |=> (fstart && !lrclk)); // R6

endmodule

// File: rtl/audio_mclk_clkgen.sv
module audio_mclk_clkgen
    import audio_mclk_pkg::*;
#(
    parameter int BITS_PER_CH = 32,
    parameter int HALF_UNIT   = 2
) (
    input  logic       clk_mclk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] mode_sel,
    output logic       bclk_o,
    output logic       lrclk_o,
    output logic       frame_start_o
);

    localparam int FRAME_BITS = 2 * BITS_PER_CH;
    localparam int BIDX_W     = $clog2(FRAME_BITS);
    localparam int MAX_PERIOD = 2 * RATIO_STEPS * HALF_UNIT;
    localparam int PH_W       = $clog2(MAX_PERIOD);

    ratio_e   cur_ratio;
    ratio_e   next_ratio;
    logic     load;
    logic     period_end;
    logic     tick;
    logic     load_active;
    clk_out_t outs;

    assign tick        = period_end && !load;
    assign load_active = (next_ratio != RATIO_NONE);

    mclk_mode_ctrl u_mode (
        .clk        (clk_mclk),
        .rst        (rst),
        .en         (en),
        .mode_in    (mode_sel),
        .period_end (period_end),
        .cur_ratio  (cur_ratio),
        .next_ratio (next_ratio),
        .load       (load)
    );

    mclk_bit_div #(
        .HALF_UNIT (HALF_UNIT),
        .PH_W      (PH_W)
    ) u_bdiv (
        .clk        (clk_mclk),
        .rst        (rst),
        .en         (en),
        .load       (load),
        .cur_ratio  (cur_ratio),
        .bclk       (outs.bclk),
        .period_end (period_end)
    );

    mclk_frame_cnt #(
        .FRAME_BITS (FRAME_BITS),
        .BIDX_W     (BIDX_W)
    ) u_frame (
        .clk         (clk_mclk),
        .rst         (rst),
        .en          (en),
        .load        (load),
        .load_active (load_active),
        .tick        (tick),
        .lrclk       (outs.lrclk),
        .fstart      (outs.fstart)
    );

    assign bclk_o        = outs.bclk;
    assign lrclk_o       = outs.lrclk;
    assign frame_start_o = outs.fstart;

    AST_RESET_QUIET: assert property (@(posedge clk_mclk) rst |=> (!bclk_o && !lrclk_o && !frame_start_o)); // R1
    AST_SLAVE_QUIET: assert property (@(posedge clk_mclk) disable iff (rst) (cur_ratio == RATIO_NONE) |-> (!bclk_o && !lrclk_o && !frame_start_o)); // R2
    AST_LR_ON_FALL: assert property (@(posedge clk_mclk) disable iff (rst) !$stable(lrclk_o) |-> $fell(bclk_o)); // R6
    AST_STROBE_FRAME_LOW: assert property (@(posedge clk_mclk) disable iff (rst) frame_start_o |-> (!lrclk_o && !bclk_o)); // R7
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk_mclk) disable iff (rst) !en |=> ($stable(bclk_o) && $stable(lrclk_o) && !frame_start_o)); // R10

endmodule

// File: tb/sim_audio_mclk_clkgen.sv
module sim_audio_mclk_clkgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic [2:0] mode = 3'b000;
    logic       bclk, lrclk, fstart;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    armed  = 0;
    string tag    = "R1";

    // reference model state
    int   m_cur = 0, m_ph = 0, m_bi = 0;
    logic m_b = 0, m_l = 0, m_f = 0;

    always #10 clk = ~clk;

    audio_mclk_clkgen u0 (
        .clk_mclk      (clk),
        .rst           (rst),
        .en            (en),
        .mode_sel      (mode),
        .bclk_o        (bclk),
        .lrclk_o       (lrclk),
        .frame_start_o (fstart)
    );

    function automatic int ratio_of(input logic [2:0] c);
        if (c == 3'b001) return 1;
        if (c == 3'b010) return 2;
        if (c == 3'b011) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        int req;
        armed <= 1'b1;
        if (rst) begin
            m_cur = 0; m_ph = 0; m_bi = 0; m_b = 0; m_l = 0; m_f = 0;
        end else if (!en) begin
            m_f = 0;
        end else begin
            req = ratio_of(mode);
            if (m_cur == 0) begin
                if (req != 0) begin
                    m_cur = req; m_ph = 0; m_bi = 0; m_b = 0; m_l = 0; m_f = 1;
                end else begin
                    m_f = 0;
                end
            end else if (m_ph == 4 * m_cur - 1) begin
                if (req != m_cur) begin
                    m_cur = req; m_ph = 0; m_bi = 0; m_b = 0; m_l = 0; m_f = (req != 0);
                end else begin
                    m_ph = 0;
                    m_bi = (m_bi + 1) % 64;
                    m_b = 0;
                    m_l = (m_bi >= 32);
                    m_f = (m_bi == 0);
                end
            end else begin
                m_ph = m_ph + 1;
                m_b = (m_ph >= 2 * m_cur);
                m_f = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (bclk !== m_b || lrclk !== m_l || fstart !== m_f) begin
                fails++;
                $display("FAIL %s t=%0t actual b/l/f=%b%b%b expected=%b%b%b",
                         tag, $time, bclk, lrclk, fstart, m_b, m_l, m_f);
            end
        end
    end

    task automatic run(input logic [2:0] m, input logic e, input int n, input string t);
        @(negedge clk);
        #1;
        mode = m;
        en   = e;
        tag  = t;
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (bclk !== 1'b0 || lrclk !== 1'b0 || fstart !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual=%b%b%b expected=000", bclk, lrclk, fstart);
        end
        #1 rst = 1'b0;
        run(3'b000, 1, 20, "R2");
        run(3'b101, 1, 20, "R2");
        run(3'b111, 1, 10, "R2");
        run(3'b100, 1, 10, "R2");
        run(3'b001, 1, 3, "R8");
        run(3'b001, 1, 600, "R3");
        run(3'b010, 1, 6, "R9");
        run(3'b010, 1, 1100, "R4");
        run(3'b011, 1, 1700, "R5");
        run(3'b011, 0, 7, "R10");
        run(3'b011, 1, 13, "R10");
        run(3'b011, 0, 3, "R10");
        run(3'b001, 0, 5, "R10");
        run(3'b001, 1, 40, "R9");
        run(3'b000, 1, 10, "R9");
        run(3'b011, 1, 800, "R6");
        run(3'b011, 1, 300, "R7");
        run(3'b010, 1, 5, "R9");
        run(3'b110, 1, 20, "R9");
        run(3'b001, 1, 30, "R8");
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired in %s", tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule